// File: doc/BRIEF.md
# Sequential Shift-Subtract Integer Divider

This block divides one W-bit integer by another over several clock cycles. It uses one shifting register that is 2W+1 bits wide and holds the partial remainder and the quotient together, and one subtractor that is W+1 bits wide. A division begins when `start` is high while the unit is idle. The dividend enters the low half of the register and is shifted left once. Each following cycle produces one quotient bit. The divisor is subtracted from the upper part. If the difference is non-negative it is kept and a 1 enters at the bottom. If it is negative, the old upper part is kept and a 0 enters. After W such steps the upper part holds the remainder, offset by one position, and the lower half holds the quotient.

`is_signed` selects two's-complement operands. In that mode both operands are first reduced to magnitudes. When the division ends, the quotient is negated if the operand signs differ, and the remainder is negated if the dividend was negative. A zero divisor raises a flag that is returned with the result. The quotient and remainder are then meaningless. Results are held on registered outputs until the next division completes.

Top module: `shiftsub_divider`

## Requirements
- R1: While `rst` is high and after it falls, `busy`, `done` and `div_by_zero` are 0, and `quotient` and `remainder` are 0 until the first division completes.
- R2: `start` is accepted only on a rising edge where `busy` is 0, and `busy` is 1 after that edge. A `start` seen while `busy` is 1 is ignored: it produces no extra `done`, and it does not change the result of the division in flight.
- R3: `done` is high for exactly one cycle. It is set by the (W+1)-th rising edge after the edge that accepted `start`, so it can first be sampled W+2 cycles after `start` was driven. `busy` is 0 whenever `done` is 1.
- R4: With `is_signed`=0, `quotient` is the floor of dividend/divisor, taking both as unsigned numbers.
- R5: With `is_signed`=0 and a non-zero divisor, `remainder` equals dividend mod divisor and is less than the divisor.
- R6: With `is_signed`=1, `quotient` is the two's-complement quotient truncated toward zero. It is negative when the operand signs differ.
- R7: With `is_signed`=1, `remainder` has the sign of the dividend (7/4 gives 1 rem 3; -7/4 gives -1 rem -3). For every non-zero divisor, quotient*divisor+remainder equals the dividend modulo 2^W.
- R8: In signed mode, the most negative value divided by -1 returns the most negative value as the quotient and 0 as the remainder.
- R9: A zero divisor sets `div_by_zero` together with `done`, with the same latency as any other division. The next completion with a non-zero divisor clears it. `quotient` and `remainder` are then unspecified.
- R10: The same bit pattern is read as unsigned or as signed according to `is_signed` at acceptance. With W=8, 8'hF9/4 gives 62 rem 1 unsigned, and -1 rem -3 (8'hFF, 8'hFD) signed.
- R11: `quotient`, `remainder` and `div_by_zero` change only on the edge that sets `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division when idle |
| is_signed | input | 1 | 1 = two's-complement operands, 0 = unsigned |
| dividend | input | W | Dividend, sampled at acceptance |
| divisor | input | W | Divisor, sampled at acceptance |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |
| div_by_zero | output | 1 | Last completed division had a zero divisor |

## Verification
The assertions assume that `start` and the operands are only meaningful on the edge where the unit is idle. They also assume that nothing arrives from outside during a run, because the operands are captured at acceptance. The stimulus therefore drives operands only together with `start`, and only at falling edges. It deliberately breaks the first assumption once, by pulsing `start` with different operands in the middle of a run, to show that the capture protects the running division. The bound on the partial remainder and the division identity hold only for a non-zero divisor, so both checks are conditioned on it. Random operand pairs include a zero divisor at regular intervals so that the flag path is also exercised.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } div_state_t;
endpackage

// File: rtl/div_magnitude.sv
module div_magnitude #(
  parameter int W = 8
) (
  input  logic [W-1:0] val,
  input  logic         signed_mode,
  output logic [W-1:0] mag,
  output logic         neg
);
  // A value is treated as negative only in signed mode with its top bit set.
  always_comb begin
    neg = signed_mode & val[W-1];
    mag = neg ? (~val + W'(1)) : val;
  end
endmodule

// File: rtl/div_ctrl.sv
module div_ctrl
  import div_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic load,
  output logic step,
  output logic finish,
  output logic busy
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  div_state_t    state_q;
  logic [CW-1:0] cnt_q;

  assign load   = (state_q == ST_IDLE) && start;
  assign step   = (state_q == ST_RUN);
  assign finish = (state_q == ST_FIX);
  assign busy   = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          cnt_q <= '0;
          if (start) state_q <= ST_RUN;
        end
        ST_RUN: begin
          cnt_q <= cnt_q + CW'(1);
          if (cnt_q == LAST) state_q <= ST_FIX;
        end
        ST_FIX:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R3: the step counter never passes the operand width.
  a_r3_count_range: assert property (@(posedge clk) disable iff (rst)
    step |-> (cnt_q <= LAST));
  // R3: the last step is always followed by the single fix-up cycle.
  a_r3_fix_after_last: assert property (@(posedge clk) disable iff (rst)
    (step && cnt_q == LAST) |=> finish);
endmodule

// File: rtl/div_core.sv
module div_core #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] dvd_mag,
  input  logic [W-1:0] dvs_mag,
  output logic [W-1:0] quo_mag,
  output logic [W-1:0] rem_mag
);
  localparam int AW = 2 * W + 1;   // upper part W+1 bits, lower half W bits

  logic [AW-1:0] acc_q;
  logic [W-1:0]  dvs_q;
  logic [W:0]    upper, diff, rem_next;
  logic [W-1:0]  lower;
  logic          fits;

  assign upper    = acc_q[AW-1:W];
  assign lower    = acc_q[W-1:0];
  assign fits     = (upper >= {1'b0, dvs_q});
  assign diff     = upper - {1'b0, dvs_q};
  assign rem_next = fits ? diff : upper;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      dvs_q <= '0;
    end else if (load) begin
      // Place the dividend low and apply the initial left shift.
      acc_q <= {{W{1'b0}}, dvd_mag, 1'b0};
      dvs_q <= dvs_mag;
    end else if (step) begin
      acc_q <= {rem_next[W-1:0], lower, fits};
    end
  end

  // The loop shifts once too often: the remainder sits one bit up.
  assign quo_mag = lower;
  assign rem_mag = acc_q[AW-1:W+1];

  // R5: the kept partial remainder always fits W bits.
  a_r5_step_fits: assert property (@(posedge clk) disable iff (rst)
    (step && dvs_q != '0) |-> !rem_next[W]);
  // R5: after each step the partial remainder is below the divisor.
  a_r5_rem_below_divisor: assert property (@(posedge clk) disable iff (rst)
    (step && dvs_q != '0) |=> (acc_q[AW-1:W+1] < dvs_q));
endmodule

// File: rtl/div_result.sv
module div_result #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         finish,
  input  logic [W-1:0] quo_mag,
  input  logic [W-1:0] rem_mag,
  input  logic         neg_quo,
  input  logic         neg_rem,
  input  logic         zero_div,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero,
  output logic         done
);
  logic [W-1:0] quo_fix, rem_fix;

  assign quo_fix = neg_quo ? (~quo_mag + W'(1)) : quo_mag;
  assign rem_fix = neg_rem ? (~rem_mag + W'(1)) : rem_mag;

  always_ff @(posedge clk) begin
    if (rst) begin
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
      done        <= 1'b0;
    end else begin
      done <= finish;
      if (finish) begin
        quotient    <= quo_fix;
        remainder   <= rem_fix;
        div_by_zero <= zero_div;
      end
    end
  end

  // R11: result registers move only on the edge that raises done.
  a_r11_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));
  // R3: done is a single-cycle pulse.
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/shiftsub_divider.sv
module shiftsub_divider #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);
  logic         load, step, finish;
  logic [W-1:0] dvd_mag, dvs_mag, quo_mag, rem_mag;
  logic         dvd_neg, dvs_neg;
  logic         negq_q, negr_q, zero_q;
  logic [W-1:0] dvd_q, dvs_q;
  logic [W-1:0] recon;

  div_ctrl #(.W(W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .load(load), .step(step), .finish(finish), .busy(busy)
  );

  div_magnitude #(.W(W)) u_mag_dvd (
    .val(dividend), .signed_mode(is_signed), .mag(dvd_mag), .neg(dvd_neg)
  );
  div_magnitude #(.W(W)) u_mag_dvs (
    .val(divisor), .signed_mode(is_signed), .mag(dvs_mag), .neg(dvs_neg)
  );

  div_core #(.W(W)) u_core (
    .clk(clk), .rst(rst), .load(load), .step(step),
    .dvd_mag(dvd_mag), .dvs_mag(dvs_mag),
    .quo_mag(quo_mag), .rem_mag(rem_mag)
  );

  // Sign and zero information captured at acceptance.
  always_ff @(posedge clk) begin
    if (rst) begin
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
      dvd_q  <= '0;
      dvs_q  <= '0;
    end else if (load) begin
      negq_q <= dvd_neg ^ dvs_neg;
      negr_q <= dvd_neg;
      zero_q <= (divisor == '0);
      dvd_q  <= dividend;
      dvs_q  <= divisor;
    end
  end

  div_result #(.W(W)) u_result (
    .clk(clk), .rst(rst), .finish(finish),
    .quo_mag(quo_mag), .rem_mag(rem_mag),
    .neg_quo(negq_q), .neg_rem(negr_q), .zero_div(zero_q),
    .quotient(quotient), .remainder(remainder),
    .div_by_zero(div_by_zero), .done(done)
  );

  assign recon = quotient * dvs_q + remainder;

  // R2: an accepted start makes the unit busy on the next cycle.
  a_r2_accept: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
  // R3: done and busy are never high together.
  a_r3_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
  // R7: every non-zero-divisor result rebuilds the captured dividend.
  a_r7_identity: assert property (@(posedge clk) disable iff (rst)
    (done && !div_by_zero) |-> (recon == dvd_q));
  // R9: the flag matches the divisor captured for this result.
  a_r9_flag: assert property (@(posedge clk) disable iff (rst)
    done |-> (div_by_zero == (dvs_q == '0)));
endmodule

// File: tb/test_shiftsub_divider.sv
`timescale 1ns/1ps
module test_shiftsub_divider;
  localparam int W = 8;
  localparam int LIMIT = 150000;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic         is_signed = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic         busy, done, div_by_zero;
  logic [W-1:0] quotient, remainder;

  shiftsub_divider #(.W(W)) i_shiftsub_divider (
    .clk(clk), .rst(rst), .start(start), .is_signed(is_signed),
    .dividend(dividend), .divisor(divisor), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .div_by_zero(div_by_zero)
  );

  always #4 clk = ~clk;   // 125 MHz

  typedef struct {
    bit           s;
    logic [W-1:0] a, b, q, r;
    bit           z;
    int           t;
    int           kind;   // 0 plain, 1 overflow case, 2 mode case
  } item_t;

  item_t        sb[$];
  int           tests = 0, fails = 0, cyc = 0;
  bit           ended = 0, prev_done = 0;
  logic [W-1:0] last_q, last_r;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic void model(input bit s, input logic [W-1:0] a, input logic [W-1:0] b,
                                output logic [W-1:0] q, output logic [W-1:0] r);
    int sa, sb2, iq, ir;
    if (b == '0) begin
      q = '0; r = '0;
    end else if (!s) begin
      q = a / b; r = a % b;
    end else begin
      sa = int'($signed(a)); sb2 = int'($signed(b));
      iq = sa / sb2; ir = sa % sb2;
      q = W'(iq); r = W'(ir);
    end
  endfunction

  task automatic issue(input bit s, input logic [W-1:0] a, input logic [W-1:0] b, input int kind);
    item_t it;
    @(negedge clk);
    while (busy) @(negedge clk);
    is_signed = s; dividend = a; divisor = b; start = 1'b1;
    it.s = s; it.a = a; it.b = b; it.z = (b == '0); it.t = cyc; it.kind = kind;
    model(s, a, b, it.q, it.r);
    sb.push_back(it);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", int'(busy), 1);
  endtask

  // Watchdog and cycle counter.
  always @(posedge clk) begin
    cyc++;
    if (cyc > LIMIT && !ended) begin
      ended = 1;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, LIMIT);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // Monitor: pops the scoreboard on each done pulse.
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        chk(!prev_done, "R3", int'(prev_done), 0);
        chk(!busy, "R3", int'(busy), 0);
        if (sb.size() == 0) begin
          chk(0, "R2", 1, 0);
        end else begin
          item_t it;
          string qtag, rtag;
          it = sb.pop_front();
          qtag = (it.kind == 1) ? "R8" : (it.kind == 2) ? "R10" : (it.s ? "R6" : "R4");
          rtag = (it.kind == 1) ? "R8" : (it.kind == 2) ? "R10" : (it.s ? "R7" : "R5");
          chk(cyc - it.t == W + 2, "R3", cyc - it.t, W + 2);
          chk(div_by_zero == it.z, "R9", int'(div_by_zero), int'(it.z));
          if (!it.z) begin
            chk(quotient == it.q, qtag, int'(quotient), int'(it.q));
            chk(remainder == it.r, rtag, int'(remainder), int'(it.r));
            if (!it.s) chk(remainder < it.b, "R5", int'(remainder), int'(it.b));
          end
        end
        last_q = quotient;
        last_r = remainder;
      end
      prev_done = done;
    end
  end

  initial begin
    // R1: reset state.
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && div_by_zero == 0, "R1", int'({busy, done, div_by_zero}), 0);
    chk(quotient == 0 && remainder == 0, "R1", int'({quotient, remainder}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0, "R1", int'({busy, done}), 0);

    // Directed cases.
    issue(0, 8'd7, 8'd4, 0);
    issue(1, 8'd7, 8'd4, 0);       // R7: 1 rem 3
    issue(1, -8'sd7, 8'd4, 0);     // R7: -1 rem -3
    issue(1, 8'd7, -8'sd4, 0);
    issue(1, -8'sd7, -8'sd4, 0);
    issue(0, 8'hFF, 8'h01, 0);
    issue(0, 8'hFF, 8'hFF, 0);
    issue(0, 8'h03, 8'hC8, 0);     // dividend below divisor
    issue(0, 8'hFE, 8'h81, 0);     // divisor with top bit set
    issue(1, 8'h80, 8'hFF, 1);     // R8: most negative / -1
    issue(0, 8'hF9, 8'd4, 2);      // R10: 62 rem 1
    issue(1, 8'hF9, 8'd4, 2);      // R10: -1 rem -3
    issue(0, 8'd55, 8'd0, 0);      // R9: zero divisor
    issue(0, 8'd55, 8'd5, 0);      // R9: flag clears

    // R2: start while busy is ignored.
    issue(0, 8'd200, 8'd7, 0);
    is_signed = 1'b1; dividend = 8'd3; divisor = 8'd1; start = 1'b1;
    repeat (2) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R2", int'(busy), 0);

    // R11: results hold while idle.
    repeat (5) @(negedge clk);
    chk(quotient == last_q, "R11", int'(quotient), int'(last_q));
    chk(remainder == last_r, "R11", int'(remainder), int'(last_r));

    // Random pairs in both modes, with periodic zero divisors.
    for (int i = 0; i < 300; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      if (i % 17 == 0) b = '0;
      issue(bit'(i % 2), a, b, 0);
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule